// File: doc/BRIEF.md
# Palette Memory Write Port

This block is the byte-wide loading path for a colour palette of 256 entries, each entry a 15-bit colour. Software (or a block-transfer engine) first selects an entry by writing an 8-bit entry address, then streams bytes into a single data port. Two bytes make one colour. The first byte goes straight into the lower eight bits of the selected entry. The second byte supplies the upper seven bits. After the second byte the port moves on to the next entry, so a whole palette can be loaded with one address write followed by a long run of data bytes.

A phase flag tracks whether the next data byte is a low or a high byte. Loading the address always brings the port back to the low-byte phase. The port presents the red, green and blue 5-bit components of the entry that is currently addressed. It also gives a one-cycle change strobe whenever a data write alters a stored colour. Downstream colour logic can use that strobe to refresh derived values.

Top module: `palette_write_port`

## Requirements
- R1: After reset every palette entry holds 0, the entry address is 0, the phase is 0 (low byte next) and the change strobe is low.
- R2: A data write in phase 0 replaces bits 7:0 of the addressed entry with the byte. The entry address stays the same, the phase becomes 1, and the new value is seen on the colour outputs in the cycle after the write edge.
- R3: A data write in phase 1 replaces bits 14:8 of the addressed entry with bits 6:0 of the byte. Bit 7 of the byte is discarded, and bits 7:0 of the entry are left unchanged.
- R4: The phase toggles on every accepted data write. The entry address increments by one only after a phase-1 write, and it wraps from 255 to 0.
- R5: An address write loads the entry address from the address input and clears the phase to 0.
- R6: If an address write and a data write occur in the same cycle, the address write takes effect and the data byte is dropped. No palette entry changes and no change strobe fires.
- R7: The change strobe is high for exactly the one cycle after an accepted data write that altered the stored entry value. It stays low after a write of identical bits.
- R8: The colour outputs show the addressed entry: red is bits 4:0, green is bits 9:5 and blue is bits 14:10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_wr | input | 1 | Load the entry address this cycle |
| addr_in | input | 8 | Entry address to load |
| data_wr | input | 1 | Write one data byte this cycle |
| data_in | input | 8 | Data byte |
| cur_addr | output | 8 | Current entry address |
| cur_phase | output | 1 | 0 means low byte next, 1 means high byte next |
| red | output | 5 | Red component of the addressed entry |
| green | output | 5 | Green component of the addressed entry |
| blue | output | 5 | Blue component of the addressed entry |
| changed | output | 1 | One-cycle strobe: the last write altered an entry |

## Verification
Every result of a write is due one clock after its edge. The address and phase are registered, the stored entry is registered, the change strobe is registered, and the colour components are decoded combinationally from those registers. The bench drives each stimulus at a falling edge and waits for the next rising edge. It then samples 1 ns later, so the address, phase, colours and strobe belong to exactly that write. An idle cycle between operations confirms that the strobe drops after one cycle.

// File: rtl/pal_pkg.sv
package pal_pkg;
    parameter int ENTRIES  = 256;
    parameter int CW       = 5;
    parameter int COLOUR_W = 3 * CW;
    parameter int BYTE_W   = 8;
    localparam int AW      = $clog2(ENTRIES);
    localparam int HI_W    = COLOUR_W - BYTE_W;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          phase;
    } ctrl_t;
endpackage

// File: rtl/pal_ctrl.sv
module pal_ctrl
    import pal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_wr,
    input  logic [AW-1:0]     addr_in,
    input  logic              data_wr,
    output logic              wr_lo,
    output logic              wr_hi,
    output logic [AW-1:0]     idx,
    output logic              phase
);
    ctrl_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        wr_lo = 1'b0;
        wr_hi = 1'b0;
        if (addr_wr) begin
            st_d.addr  = addr_in;
            st_d.phase = 1'b0;
        end else if (data_wr) begin
            wr_lo      = ~st_q.phase;
            wr_hi      = st_q.phase;
            st_d.phase = ~st_q.phase;
            if (st_q.phase)
                st_d.addr = st_q.addr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idx   = st_q.addr;
    assign phase = st_q.phase;

    assert_low_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !addr_wr && !phase) |=> (phase && idx == $past(idx)));

    assert_addr_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !addr_wr && phase) |=> (!phase && idx == $past(idx) + 1'b1));

    assert_addr_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        addr_wr |=> (!phase && idx == $past(addr_in)));
endmodule

// File: rtl/pal_store.sv
module pal_store
    import pal_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [AW-1:0]       idx,
    input  logic [BYTE_W-1:0]   byte_in,
    output logic [COLOUR_W-1:0] entry,
    output logic                chg
);
    typedef struct packed {
        logic [ENTRIES-1:0][COLOUR_W-1:0] ent;
        logic                             chg;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.chg = 1'b0;
        if (wr_lo) begin
            st_d.ent[idx][BYTE_W-1:0] = byte_in;
            st_d.chg = (byte_in != st_q.ent[idx][BYTE_W-1:0]);
        end else if (wr_hi) begin
            st_d.ent[idx][COLOUR_W-1:BYTE_W] = byte_in[HI_W-1:0];
            st_d.chg = (byte_in[HI_W-1:0] != st_q.ent[idx][COLOUR_W-1:BYTE_W]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign entry = st_q.ent[idx];
    assign chg   = st_q.chg;

    assert_strobe_needs_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chg |-> $past(wr_lo || wr_hi));

    assert_hi_keeps_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (st_q.ent[$past(idx)][BYTE_W-1:0] == $past(st_q.ent[idx][BYTE_W-1:0])));

    assert_lo_keeps_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (st_q.ent[$past(idx)][COLOUR_W-1:BYTE_W] == $past(st_q.ent[idx][COLOUR_W-1:BYTE_W])));
endmodule

// File: rtl/pal_split.sv
module pal_split
    import pal_pkg::*;
(
    input  logic [COLOUR_W-1:0] entry,
    output logic [CW-1:0]       red,
    output logic [CW-1:0]       green,
    output logic [CW-1:0]       blue
);
    logic [2:0][CW-1:0] comp;

    for (genvar g = 0; g < 3; g++) begin : g_comp
        assign comp[g] = entry[g*CW +: CW];
    end

    assign red   = comp[0];
    assign green = comp[1];
    assign blue  = comp[2];
endmodule

// File: rtl/palette_write_port.sv
module palette_write_port
    import pal_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_wr,
    input  logic [7:0]    addr_in,
    input  logic          data_wr,
    input  logic [7:0]    data_in,
    output logic [7:0]    cur_addr,
    output logic          cur_phase,
    output logic [4:0]    red,
    output logic [4:0]    green,
    output logic [4:0]    blue,
    output logic          changed
);
    logic                wr_lo, wr_hi;
    logic [AW-1:0]       idx;
    logic [COLOUR_W-1:0] entry;

    pal_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .addr_in(addr_in),
        .data_wr(data_wr), .wr_lo(wr_lo), .wr_hi(wr_hi), .idx(idx), .phase(cur_phase)
    );

    pal_store u_store (
        .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .idx(idx),
        .byte_in(data_in), .entry(entry), .chg(changed)
    );

    pal_split u_split (
        .entry(entry), .red(red), .green(green), .blue(blue)
    );

    assign cur_addr = idx;

    assert_both_drops_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_wr && data_wr) |=> !changed);
endmodule

// File: tb/palette_write_port_tb.sv
module palette_write_port_tb;
    logic clk = 0, rst_n = 0;
    logic addr_wr = 0, data_wr = 0;
    logic [7:0] addr_in = 0, data_in = 0;
    logic [7:0] cur_addr;
    logic cur_phase, changed;
    logic [4:0] red, green, blue;

    int checks = 0, errors = 0;
    logic [14:0] model [256];
    logic [7:0]  m_addr;
    logic        m_phase;
    logic        m_chg;
    bit          done = 0;

    always #5 clk = ~clk;

    palette_write_port u_dut (
        .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .addr_in(addr_in),
        .data_wr(data_wr), .data_in(data_in), .cur_addr(cur_addr),
        .cur_phase(cur_phase), .red(red), .green(green), .blue(blue),
        .changed(changed)
    );

    function automatic logic [4:0] exp_r(logic [14:0] v); return v[4:0];   endfunction
    function automatic logic [4:0] exp_g(logic [14:0] v); return v[9:5];   endfunction
    function automatic logic [4:0] exp_b(logic [14:0] v); return v[14:10]; endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        chk({req, " addr"},   {8'h0, cur_addr},  {8'h0, m_addr});
        chk({req, " phase"},  {15'h0, cur_phase}, {15'h0, m_phase});
        chk({req, " red R8"},   {11'h0, red},   {11'h0, exp_r(model[m_addr])});
        chk({req, " green R8"}, {11'h0, green}, {11'h0, exp_g(model[m_addr])});
        chk({req, " blue R8"},  {11'h0, blue},  {11'h0, exp_b(model[m_addr])});
        chk({req, " strobe R7"}, {15'h0, changed}, {15'h0, m_chg});
    endtask

    task automatic op(bit aw, logic [7:0] a, bit dw, logic [7:0] d, string req);
        logic [14:0] old;
        @(negedge clk);
        addr_wr = aw; addr_in = a; data_wr = dw; data_in = d;
        m_chg = 0;
        if (aw) begin
            m_addr = a; m_phase = 0;
        end else if (dw) begin
            old = model[m_addr];
            if (!m_phase) model[m_addr][7:0] = d;
            else          model[m_addr][14:8] = d[6:0];
            m_chg = (old != model[m_addr]);
            if (m_phase) m_addr = m_addr + 8'd1;
            m_phase = ~m_phase;
        end
        @(posedge clk); #1;
        addr_wr = 0; data_wr = 0;
        check_all(req);
    endtask

    task automatic idle(string req);
        op(0, 8'h00, 0, 8'h00, req);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unused;
        unused = $urandom(32'd1234);
        for (int i = 0; i < 256; i++) model[i] = '0;
        m_addr = 0; m_phase = 0; m_chg = 0;
        repeat (3) @(posedge clk);
        #1;
        check_all("R1 reset");
        @(negedge clk); rst_n = 1;
        @(posedge clk); #1;
        check_all("R1 after release");

        // R5 address load, R2 low write, R3 high write with bit7 discarded
        op(1, 8'h10, 0, 8'h00, "R5 load");
        op(0, 8'h00, 1, 8'hA5, "R2 low byte");
        op(0, 8'h00, 1, 8'hFF, "R3 high byte");
        op(1, 8'h10, 0, 8'h00, "R3 readback");
        chk("R3 bit7 dropped blue", {11'h0, blue}, 16'h001F);
        // R7 identical write gives no strobe
        op(0, 8'h00, 1, 8'hA5, "R7 same low");
        op(0, 8'h00, 1, 8'h7F, "R7 same high");
        idle("R7 idle");
        // R4 wrap 255 -> 0
        op(1, 8'hFF, 0, 8'h00, "R4 load 255");
        op(0, 8'h00, 1, 8'h12, "R4 low at 255");
        op(0, 8'h00, 1, 8'h34, "R4 wrap");
        // R5 load mid-pair clears phase
        op(0, 8'h00, 1, 8'h55, "R5 pre");
        op(1, 8'h20, 0, 8'h00, "R5 clears phase");
        // R6 simultaneous writes
        op(1, 8'h30, 1, 8'hEE, "R6 both");
        op(1, 8'h00, 0, 8'h00, "R6 readback");

        for (int n = 0; n < 4000; n++) begin
            int sel = $urandom_range(0, 19);
            logic [7:0] a = 8'($urandom);
            logic [7:0] d = 8'($urandom);
            if (sel == 0)      op(1, a, 0, d, "R5 random load");
            else if (sel == 1) op(1, a, 1, d, "R6 random both");
            else if (sel == 2) idle("R7 random idle");
            else               op(0, a, 1, d, "R4 random data");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule